// File: doc/BRIEF.md
# Protocol Discovery Enumerator with Lookup

This block runs once a mailbox is brought up. It first asks the requester engine to reset the mailbox with an abort. It then walks the mailbox's list of supported protocols by issuing discovery exchanges, one after another. Each exchange goes to the standards-body vendor ID with protocol type 0. The request payload names the index being asked for. The device answers each request with a single dword. That dword gives one supported (vendor, type) pair and the index to ask for next. Each pair goes into a small table. The walk ends when the device returns a next index of zero.

After a good walk, the block raises `ready`. From then on, a lookup port reports whether a given (vendor, type) pair is supported. Task submission through `sub_req` / `sub_accept` is granted only while `ready` is high and the pair is supported. The discovery pair is always reported as supported, whether or not it is in the table. Any failure stops the walk in a failed state with an error code: a failed abort, a bad exchange, or a table that is already full.

The sequencer has six states:
- `ST_IDLE`: after reset.
- `ST_ABORT`: abort requested, waiting for it to finish.
- `ST_ISSUE`: a request is offered.
- `ST_WAIT`: waiting for the response.
- `ST_DONE`: the walk finished well.
- `ST_FAIL`: the walk failed.

It has these transitions:
- launch: `start` in IDLE, DONE or FAIL goes to ABORT.
- abort ok: goes to ISSUE.
- abort bad: goes to FAIL.
- accepted: ISSUE goes to WAIT on `xreq_ready`.
- more: a good response with a non-zero next index goes back to ISSUE.
- last: a good response with a zero next index goes to DONE.
- bad response: goes to FAIL.
- overflow: goes to FAIL.

Top module: `discovery_enum`

## Requirements
- R1: After reset, `ready`, `fail`, `abort_req` and `xreq_valid` are low, and the table holds no entries.
- R2: When `start` is seen in IDLE, DONE or FAIL, `abort_req` rises the next cycle. It stays high until `abort_done`. If `abort_fail` comes with `abort_done`, the block enters FAIL with `err_code` 1 and issues no request.
- R3: Every request carries vendor `DISC_VID` (default 16'h0001) and type 0. The payload holds the index in bits [7:0] and the version in bits [15:8], with bits [31:16] zero. The version is 2 when `cap_ver` was at least 2 at launch, and 0 otherwise. The first index is 0. The request stays stable while `xreq_ready` is low.
- R4: A response dword holds the vendor in bits [15:0], the type in bits [23:16] and the next index in bits [31:24]. A non-zero next index becomes the index of the next request. A zero next index ends the walk.
- R5: A response with `xrsp_err` high, or with `xrsp_len` (in dwords) other than 1, puts the block in FAIL with `err_code` 2.
- R6: Each good response stores one entry. If `DEPTH` entries are already stored when another good response arrives, the block enters FAIL with `err_code` 3. The stored entries are kept.
- R7: `lk_hit` is high in the same cycle when the key `{lk_vid, lk_type}`, which is vendor<<8 | type, equals any stored entry.
- R8: `lk_hit` is always high for vendor `DISC_VID` with type 0.
- R9: `ready` rises in the cycle after the final response and stays high until the next launch. `sub_accept` is `sub_req & ready & lk_hit`.
- R10: `start` is ignored while ABORT, ISSUE or WAIT is in progress. A launch from DONE or FAIL clears the table and runs the whole sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch the abort and the discovery walk |
| cap_ver | input | CAPV_W | Capability version; picks the request version field |
| abort_req | output | 1 | Mailbox abort request |
| abort_done | input | 1 | Abort finished |
| abort_fail | input | 1 | With abort_done: the abort failed |
| xreq_valid | output | 1 | Discovery request offered |
| xreq_ready | input | 1 | Requester accepts the request |
| xreq_vid | output | 16 | Request vendor ID |
| xreq_type | output | 8 | Request protocol type |
| xreq_payload | output | 32 | Request payload dword |
| xrsp_valid | input | 1 | Response available |
| xrsp_err | input | 1 | The exchange failed |
| xrsp_len | input | LEN_W | Response payload length in dwords |
| xrsp_data | input | 32 | First response payload dword |
| lk_vid | input | 16 | Lookup vendor ID |
| lk_type | input | 8 | Lookup protocol type |
| lk_hit | output | 1 | Pair is supported |
| sub_req | input | 1 | Task submission request for the looked-up pair |
| sub_accept | output | 1 | Submission granted |
| ready | output | 1 | Walk completed well |
| fail | output | 1 | Walk failed |
| err_code | output | 2 | 0 none, 1 abort, 2 exchange, 3 overflow |

## Verification
The final good response writes the last table entry and raises `ready` on the same clock edge. A lookup aimed at that entry can therefore race the readiness gate. To provoke this, the bench holds `sub_req` high with the lookup set to the pair the last response will deliver, before the walk is launched. It then checks every cycle of the walk. `sub_accept` must stay low until `ready` is seen. In the first cycle that `ready` is seen, both the table hit and the grant must be present.

// File: rtl/disc_pkg.sv
package disc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ABORT,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE,
        ST_FAIL
    } disc_state_e;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_ABORT = 2'd1,
        ERR_XCHG  = 2'd2,
        ERR_OVF   = 2'd3
    } disc_err_e;

    localparam int DWORD_W = 32;
    localparam int VER_W   = 8;
endpackage

// File: rtl/disc_table.sv
module disc_table #(
    parameter int DEPTH = 8,
    parameter int KEY_W = 24,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wr_key,
    input  logic [KEY_W-1:0] lk_key,
    output logic             lk_hit,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    logic [DEPTH-1:0] valid_q;
    logic [KEY_W-1:0] key_q [DEPTH];
    logic [DEPTH-1:0] hit_vec;
    logic [CNT_W-1:0] count_q;

    assign full  = (count_q == CNT_W'(DEPTH));
    assign count = count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr) begin
            count_q <= '0;
        end else if (wr_en && !full) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
            end else if (clr) begin
                valid_q[i] <= 1'b0;
            end else if (wr_en && count_q == CNT_W'(i)) begin
                valid_q[i] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!clr && wr_en && count_q == CNT_W'(i)) begin
                key_q[i] <= wr_key;
            end
        end

        assign hit_vec[i] = valid_q[i] && (key_q[i] == lk_key);
    end

    assign lk_hit = |hit_vec;
endmodule

// File: rtl/disc_seq.sv
module disc_seq
    import disc_pkg::*;
#(
    parameter int VID_W  = 16,
    parameter int TYPE_W = 8,
    parameter int IDX_W  = 8,
    parameter int CAPV_W = 4,
    parameter int LEN_W  = 19,
    localparam int KEY_W = VID_W + TYPE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CAPV_W-1:0]  cap_ver,
    input  logic               abort_done,
    input  logic               abort_fail,
    input  logic               xreq_ready,
    input  logic               xrsp_valid,
    input  logic               xrsp_err,
    input  logic [LEN_W-1:0]   xrsp_len,
    input  logic [DWORD_W-1:0] xrsp_data,
    input  logic               tbl_full,
    output logic               abort_req,
    output logic               xreq_valid,
    output logic [DWORD_W-1:0] xreq_payload,
    output logic               tbl_clr,
    output logic               tbl_wr,
    output logic [KEY_W-1:0]   tbl_key,
    output logic               ready,
    output logic               fail,
    output logic [1:0]         err_code
);
    localparam int PAD_W = DWORD_W - IDX_W - VER_W;

    disc_state_e        state_q, state_d;
    logic [IDX_W-1:0]   idx_q;
    logic [VER_W-1:0]   ver_q;
    disc_err_e          err_q;
    logic               launch;
    logic               rsp_ok;
    logic [IDX_W-1:0]   rsp_next;
    logic [VID_W-1:0]   rsp_vid;
    logic [TYPE_W-1:0]  rsp_type;

    assign rsp_ok   = !xrsp_err && (xrsp_len == LEN_W'(1));
    assign rsp_vid  = xrsp_data[VID_W-1:0];
    assign rsp_type = xrsp_data[VID_W +: TYPE_W];
    assign rsp_next = xrsp_data[VID_W + TYPE_W +: IDX_W];
    assign launch   = start && (state_q == ST_IDLE || state_q == ST_DONE || state_q == ST_FAIL);

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (launch) state_d = ST_ABORT;
            end
            ST_ABORT: begin
                if (abort_done) state_d = abort_fail ? ST_FAIL : ST_ISSUE;
            end
            ST_ISSUE: begin
                if (xreq_ready) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (xrsp_valid) begin
                    if (!rsp_ok || tbl_full)     state_d = ST_FAIL;
                    else if (rsp_next == '0)     state_d = ST_DONE;
                    else                         state_d = ST_ISSUE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // walk index, version and error code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            ver_q <= '0;
            err_q <= ERR_NONE;
        end else if (launch) begin
            idx_q <= '0;
            ver_q <= (cap_ver >= CAPV_W'(2)) ? VER_W'(2) : VER_W'(0);
            err_q <= ERR_NONE;
        end else if (state_q == ST_ABORT && abort_done && abort_fail) begin
            err_q <= ERR_ABORT;
        end else if (state_q == ST_WAIT && xrsp_valid) begin
            if (!rsp_ok)       err_q <= ERR_XCHG;
            else if (tbl_full) err_q <= ERR_OVF;
            else               idx_q <= rsp_next;
        end
    end

    // outputs per state
    always_comb begin
        abort_req  = 1'b0;
        xreq_valid = 1'b0;
        tbl_wr     = 1'b0;
        ready      = 1'b0;
        fail       = 1'b0;
        unique case (state_q)
            ST_ABORT: abort_req  = 1'b1;
            ST_ISSUE: xreq_valid = 1'b1;
            ST_WAIT:  tbl_wr     = xrsp_valid && rsp_ok && !tbl_full;
            ST_DONE:  ready      = 1'b1;
            ST_FAIL:  fail       = 1'b1;
            default:  ;
        endcase
    end

    assign tbl_clr      = launch;
    assign tbl_key      = {rsp_vid, rsp_type};
    assign xreq_payload = {{PAD_W{1'b0}}, ver_q, idx_q};
    assign err_code     = err_q;
endmodule

// File: rtl/discovery_enum.sv
module discovery_enum
    import disc_pkg::*;
#(
    parameter int          DEPTH    = 8,
    parameter int          CAPV_W   = 4,
    parameter int          LEN_W    = 19,
    parameter logic [15:0] DISC_VID = 16'h0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CAPV_W-1:0] cap_ver,
    output logic              abort_req,
    input  logic              abort_done,
    input  logic              abort_fail,
    output logic              xreq_valid,
    input  logic              xreq_ready,
    output logic [15:0]       xreq_vid,
    output logic [7:0]        xreq_type,
    output logic [31:0]       xreq_payload,
    input  logic              xrsp_valid,
    input  logic              xrsp_err,
    input  logic [LEN_W-1:0]  xrsp_len,
    input  logic [31:0]       xrsp_data,
    input  logic [15:0]       lk_vid,
    input  logic [7:0]        lk_type,
    output logic              lk_hit,
    input  logic              sub_req,
    output logic              sub_accept,
    output logic              ready,
    output logic              fail,
    output logic [1:0]        err_code
);
    localparam int VID_W  = 16;
    localparam int TYPE_W = 8;
    localparam int KEY_W  = VID_W + TYPE_W;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic             tbl_clr;
    logic             tbl_wr;
    logic [KEY_W-1:0] tbl_key;
    logic             tbl_full;
    logic             tbl_hit;
    logic [CNT_W-1:0] tbl_count;
    logic             disc_pair;

    disc_seq #(
        .VID_W (VID_W),
        .TYPE_W(TYPE_W),
        .IDX_W (8),
        .CAPV_W(CAPV_W),
        .LEN_W (LEN_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cap_ver     (cap_ver),
        .abort_done  (abort_done),
        .abort_fail  (abort_fail),
        .xreq_ready  (xreq_ready),
        .xrsp_valid  (xrsp_valid),
        .xrsp_err    (xrsp_err),
        .xrsp_len    (xrsp_len),
        .xrsp_data   (xrsp_data),
        .tbl_full    (tbl_full),
        .abort_req   (abort_req),
        .xreq_valid  (xreq_valid),
        .xreq_payload(xreq_payload),
        .tbl_clr     (tbl_clr),
        .tbl_wr      (tbl_wr),
        .tbl_key     (tbl_key),
        .ready       (ready),
        .fail        (fail),
        .err_code    (err_code)
    );

    disc_table #(
        .DEPTH(DEPTH),
        .KEY_W(KEY_W)
    ) u_tbl (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tbl_clr),
        .wr_en (tbl_wr),
        .wr_key(tbl_key),
        .lk_key({lk_vid, lk_type}),
        .lk_hit(tbl_hit),
        .full  (tbl_full),
        .count (tbl_count)
    );

    assign disc_pair  = (lk_vid == DISC_VID) && (lk_type == '0);
    assign lk_hit     = tbl_hit || disc_pair;
    assign sub_accept = sub_req && ready && lk_hit;
    assign xreq_vid   = DISC_VID;
    assign xreq_type  = '0;
endmodule

// File: rtl/disc_chk.sv
module disc_chk #(
    parameter int          DEPTH    = 8,
    parameter logic [15:0] DISC_VID = 16'h0001,
    localparam int         CNT_W    = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             abort_req,
    input logic             abort_done,
    input logic             xreq_valid,
    input logic             xreq_ready,
    input logic [15:0]      xreq_vid,
    input logic [7:0]       xreq_type,
    input logic [31:0]      xreq_payload,
    input logic             xrsp_valid,
    input logic [15:0]      lk_vid,
    input logic [7:0]       lk_type,
    input logic             lk_hit,
    input logic             ready,
    input logic             fail,
    input logic [1:0]       err_code,
    input logic [CNT_W-1:0] tbl_count
);
    // R1
    ready_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && fail));

    // R2
    abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req && !abort_done |=> abort_req);

    // R3
    req_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xreq_valid |-> (xreq_vid == DISC_VID && xreq_type == 8'd0 && xreq_payload[31:16] == 16'd0));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xreq_valid && !xreq_ready |=> xreq_valid && $stable(xreq_payload));

    // R5
    fail_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> err_code != 2'd0);

    // R6
    tbl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_count <= CNT_W'(DEPTH));

    // R8
    disc_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_vid == DISC_VID && lk_type == 8'd0) |-> lk_hit);

    // R9
    ready_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(xrsp_valid));

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && xreq_valid |=> !abort_req);
endmodule

bind discovery_enum disc_chk #(
    .DEPTH   (DEPTH),
    .DISC_VID(DISC_VID)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .abort_req   (abort_req),
    .abort_done  (abort_done),
    .xreq_valid  (xreq_valid),
    .xreq_ready  (xreq_ready),
    .xreq_vid    (xreq_vid),
    .xreq_type   (xreq_type),
    .xreq_payload(xreq_payload),
    .xrsp_valid  (xrsp_valid),
    .lk_vid      (lk_vid),
    .lk_type     (lk_type),
    .lk_hit      (lk_hit),
    .ready       (ready),
    .fail        (fail),
    .err_code    (err_code),
    .tbl_count   (tbl_count)
);

// File: tb/sim_discovery_enum.sv
module sim_discovery_enum;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  cap_ver = '0;
    logic        abort_req;
    logic        abort_done = 1'b0;
    logic        abort_fail = 1'b0;
    logic        xreq_valid;
    logic        xreq_ready = 1'b1;
    logic [15:0] xreq_vid;
    logic [7:0]  xreq_type;
    logic [31:0] xreq_payload;
    logic        xrsp_valid = 1'b0;
    logic        xrsp_err = 1'b0;
    logic [18:0] xrsp_len = '0;
    logic [31:0] xrsp_data = '0;
    logic [15:0] lk_vid = '0;
    logic [7:0]  lk_type = '0;
    logic        lk_hit;
    logic        sub_req = 1'b0;
    logic        sub_accept;
    logic        ready;
    logic        fail;
    logic [1:0]  err_code;

    int total = 0;
    int bad = 0;
    int abort_cnt = 0;
    bit abort_fail_cfg = 1'b0;
    bit rsp_pend = 1'b0;
    bit ab_pend = 1'b0;
    logic [31:0] exp_q [$];
    logic [51:0] rsp_q [$];
    logic [31:0] exp_item;
    logic [51:0] rsp_item;

    discovery_enum #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cap_ver(cap_ver),
        .abort_req(abort_req), .abort_done(abort_done), .abort_fail(abort_fail),
        .xreq_valid(xreq_valid), .xreq_ready(xreq_ready), .xreq_vid(xreq_vid),
        .xreq_type(xreq_type), .xreq_payload(xreq_payload),
        .xrsp_valid(xrsp_valid), .xrsp_err(xrsp_err), .xrsp_len(xrsp_len),
        .xrsp_data(xrsp_data), .lk_vid(lk_vid), .lk_type(lk_type), .lk_hit(lk_hit),
        .sub_req(sub_req), .sub_accept(sub_accept), .ready(ready), .fail(fail),
        .err_code(err_code)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp_v);
        end
    endtask

    function automatic logic [51:0] mk_rsp(input logic [15:0] vid, input logic [7:0] typ, input logic [7:0] nxt);
        return {1'b0, 19'd1, nxt, typ, vid};
    endfunction

    task automatic push_req(input logic [3:0] cap, input logic [7:0] idx);
        exp_q.push_back({16'h0000, (cap >= 4'd2) ? 8'd2 : 8'd0, idx});
    endtask

    // monitor: pops the expected request on each accepted request (R3, R4)
    always @(negedge clk) begin
        if (rst_n && xreq_valid && xreq_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected request", xreq_payload, 32'h0);
            end else begin
                exp_item = exp_q.pop_front();
                chk(xreq_payload == exp_item && xreq_vid == 16'h0001 && xreq_type == 8'h00,
                    "R3 request payload", xreq_payload, exp_item);
            end
        end
    end

    // device model: answers one cycle after an accepted request
    always @(negedge clk) begin
        xrsp_valid = 1'b0;
        if (rsp_pend && rsp_q.size() > 0) begin
            rsp_item = rsp_q.pop_front();
            {xrsp_err, xrsp_len, xrsp_data} = rsp_item;
            xrsp_valid = 1'b1;
        end
        rsp_pend = rst_n && xreq_valid && xreq_ready;
    end

    // abort model
    always @(negedge clk) begin
        abort_done = 1'b0;
        abort_fail = 1'b0;
        if (ab_pend) begin
            abort_done = 1'b1;
            abort_fail = abort_fail_cfg;
            abort_cnt++;
        end
        ab_pend = rst_n && abort_req && !abort_done;
    end

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end();
        for (int n = 0; n < 1000 && !(ready || fail); n++) @(negedge clk);
        #1;
    endtask

    task automatic lk(input logic [15:0] vid, input logic [7:0] typ, input bit exp_v, input string tag);
        lk_vid = vid;
        lk_type = typ;
        #1;
        chk(lk_hit == exp_v, tag, {31'h0, lk_hit}, {31'h0, exp_v});
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R9 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int ab0;
        int viol;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk(!ready && !fail, "R1 ready/fail after reset", {30'h0, ready, fail}, 32'h0);
        chk(!abort_req && !xreq_valid, "R1 requests idle", {30'h0, abort_req, xreq_valid}, 32'h0);
        lk(16'h1234, 8'h02, 1'b0, "R1 table empty");
        lk(16'h0001, 8'h00, 1'b1, "R8 discovery pair at reset");
        rst_n = 1'b1;

        // A: three-entry walk, capability version 1 gives version field 0 (R3, R4, R7, R9)
        cap_ver = 4'd1;
        push_req(4'd1, 8'd0); push_req(4'd1, 8'd1); push_req(4'd1, 8'd2);
        rsp_q.push_back(mk_rsp(16'h0001, 8'h00, 8'd1));
        rsp_q.push_back(mk_rsp(16'h1E98, 8'h05, 8'd2));
        rsp_q.push_back(mk_rsp(16'h1234, 8'h02, 8'd0));
        pulse_start();
        wait_end();
        chk(ready && err_code == 2'd0, "R9 ready after walk", {29'h0, err_code, ready}, 32'h1);
        chk(exp_q.size() == 0, "R4 walk ended at zero index", exp_q.size(), 32'h0);
        lk(16'h1E98, 8'h05, 1'b1, "R7 stored pair 1E98/05");
        lk(16'h1234, 8'h02, 1'b1, "R7 stored pair 1234/02");
        lk(16'h1234, 8'h05, 1'b0, "R7 crossed pair misses");
        sub_req = 1'b1;
        lk(16'h1E98, 8'h05, 1'b1, "R7 lookup for grant");
        chk(sub_accept, "R9 grant for supported pair", {31'h0, sub_accept}, 32'h1);
        lk(16'h5555, 8'h01, 1'b0, "R7 unknown pair");
        chk(!sub_accept, "R9 no grant for unknown pair", {31'h0, sub_accept}, 32'h0);
        repeat (5) @(negedge clk);
        #1;
        chk(ready, "R9 ready holds", {31'h0, ready}, 32'h1);

        // B: version 2, same-cycle race between last write and grant (R3, R8, R9, R10)
        cap_ver = 4'd2;
        push_req(4'd2, 8'd0); push_req(4'd2, 8'd7);
        rsp_q.push_back(mk_rsp(16'h1AB4, 8'h01, 8'd7));
        rsp_q.push_back(mk_rsp(16'h1AB4, 8'h03, 8'd0));
        lk_vid = 16'h1AB4;
        lk_type = 8'h03;
        sub_req = 1'b1;
        pulse_start();
        viol = 0;
        for (int n = 0; n < 1000 && !ready && !fail; n++) begin
            @(negedge clk);
            #1;
            if (!ready && sub_accept) viol++;
        end
        chk(viol == 0, "R9 no grant before ready", viol, 32'h0);
        chk(ready && lk_hit && sub_accept, "R9 hit and grant with ready",
            {29'h0, ready, lk_hit, sub_accept}, 32'h7);
        lk(16'h1E98, 8'h05, 1'b0, "R10 old entry cleared");
        lk(16'h0001, 8'h00, 1'b1, "R8 discovery pair not in table");
        chk(sub_accept, "R8 grant for discovery pair", {31'h0, sub_accept}, 32'h1);
        sub_req = 1'b0;

        // C: start held through ABORT, ISSUE and WAIT is ignored (R10)
        cap_ver = 4'd0;
        push_req(4'd0, 8'd0);
        rsp_q.push_back(mk_rsp(16'h2222, 8'h09, 8'd0));
        ab0 = abort_cnt;
        @(negedge clk);
        start = 1'b1;
        repeat (5) @(negedge clk);
        start = 1'b0;
        wait_end();
        repeat (3) @(negedge clk);
        #1;
        chk(abort_cnt - ab0 == 1, "R10 single abort while busy", abort_cnt - ab0, 32'h1);
        chk(ready, "R10 walk completes", {31'h0, ready}, 32'h1);
        lk(16'h2222, 8'h09, 1'b1, "R7 stored pair 2222/09");

        // D: response length 2 fails (R5)
        push_req(4'd0, 8'd0);
        rsp_q.push_back({1'b0, 19'd2, 8'd0, 8'h01, 16'h4444});
        pulse_start();
        wait_end();
        chk(fail && err_code == 2'd2, "R5 bad length", {29'h0, err_code, fail}, 32'h5);
        sub_req = 1'b1;
        lk(16'h0001, 8'h00, 1'b1, "R8 discovery pair in fail");
        chk(!sub_accept && !ready, "R9 refused while not ready", {30'h0, sub_accept, ready}, 32'h0);
        sub_req = 1'b0;

        // E: error flag fails (R5)
        push_req(4'd0, 8'd0);
        rsp_q.push_back({1'b1, 19'd1, 8'd0, 8'h01, 16'h4444});
        pulse_start();
        wait_end();
        chk(fail && err_code == 2'd2, "R5 error flag", {29'h0, err_code, fail}, 32'h5);
        lk(16'h4444, 8'h01, 1'b0, "R5 bad response not stored");

        // F: failed abort (R2)
        abort_fail_cfg = 1'b1;
        pulse_start();
        wait_end();
        repeat (4) @(negedge clk);
        #1;
        chk(fail && err_code == 2'd1, "R2 abort failure", {29'h0, err_code, fail}, 32'h3);
        abort_fail_cfg = 1'b0;

        // G: table overflow with DEPTH=4 (R6)
        for (int i = 0; i < 5; i++) begin
            push_req(4'd0, 8'(i));
            rsp_q.push_back(mk_rsp(16'h3000 + 16'(i), 8'(i), 8'(i + 1)));
        end
        pulse_start();
        wait_end();
        chk(fail && err_code == 2'd3, "R6 overflow", {29'h0, err_code, fail}, 32'h7);
        lk(16'h3003, 8'h03, 1'b1, "R6 fourth entry kept");
        lk(16'h3004, 8'h04, 1'b0, "R6 fifth entry dropped");

        // H: recovery after failure (R10)
        push_req(4'd0, 8'd0);
        rsp_q.push_back(mk_rsp(16'h7777, 8'h11, 8'd0));
        pulse_start();
        wait_end();
        chk(ready && err_code == 2'd0, "R10 rerun after fail", {29'h0, err_code, ready}, 32'h1);
        lk(16'h3003, 8'h03, 1'b0, "R10 overflow entries cleared");
        lk(16'h7777, 8'h11, 1'b1, "R7 stored pair 7777/11");

        chk(exp_q.size() == 0 && rsp_q.size() == 0, "R4 scoreboard drained",
            exp_q.size() + rsp_q.size(), 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule